// File: doc/BRIEF.md
# Cross-Product Phase Error Detector with Saturating PI Loop Filter

This block is the phase-error and loop-filter stage of a sampled, fixed-point single-phase grid-synchronisation loop. Each time the sample strobe fires, it takes four signed words. The first is the grid voltage sample. The second is the same waveform delayed by a quarter period, which carries the negated cosine of the grid phase. The last two are the cosine and the sine of the phase estimated by the oscillator.

The block multiplies the in-phase sample by the estimated cosine and the quadrature sample by the estimated sine, then adds the two products. The sum equals the input amplitude times the sine of the phase difference. It has no double-frequency term, so no ripple filter follows it. The sum is rounded to an error word. A proportional-integral controller with run-time gains turns that error into a frequency-correction word for the oscillator. A word of zero stands for the nominal grid frequency.

When the loop is locked the error is exactly zero whatever the input amplitude, so an amplitude step leaves the correction word unchanged. A sequencing state machine has two states. In ST_WAIT it waits for a strobe. Transition T_ACCEPT (strobe seen in ST_WAIT) latches the rounded error and moves to ST_ACCUM. In ST_ACCUM it updates the integrator and the output. Transition T_DONE is unconditional and returns the machine to ST_WAIT on the next edge.

Top module: `qpd_phase_pi`

## Requirements
- R1: While reset is high, and on the first edge after it, `phase_err`, `freq_word` and `freq_valid` read zero and the integrator is empty. The first update after reset therefore contains no earlier history.
- R2: On the clock edge where a strobe is accepted, `phase_err` loads round((grid_in·est_cos + grid_quad·est_sin) / 512) with halves rounded upward, i.e. floor((sum + 256) / 512). The products are full 32-bit, the sum is 33-bit, and `grid_quad` is used with its sign unchanged.
- R3: One clock after an accepted strobe, `freq_word` = clamp(floor(kp·e / 256) + I). Here e is the latched error, I is the integrator value after that update, and kp is unsigned Q8.8.
- R4: On each accepted strobe the integrator becomes clamp(I_old + floor(ki·e / 256)), with ki unsigned Q8.8 and floor toward minus infinity.
- R5: The integrator saturates at +8388608 and −8388608 and never wraps.
- R6: `freq_word` saturates at +8388608 and −8388608.
- R7: `freq_valid` is high for exactly the one clock that follows the update edge. The update edge is one clock after the accepted strobe.
- R8: A strobe in the clock immediately after an accepted strobe (state ST_ACCUM) is ignored. `phase_err` keeps the first sample's error and no second valid pulse follows.
- R9: Between updates, `freq_word` and `phase_err` hold their values.
- R10: When the inputs match the estimate (grid_in = A·s, grid_quad = −A·c, est_sin = k·s, est_cos = k·c), the error is zero for every amplitude A. `freq_word` then stays at its held value across amplitude steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Single-cycle sample strobe |
| grid_in | input | 16 | Signed grid voltage sample |
| grid_quad | input | 16 | Signed quarter-period-delayed sample (negated cosine) |
| est_cos | input | 16 | Signed cosine of estimated phase |
| est_sin | input | 16 | Signed sine of estimated phase |
| kp_gain | input | 16 | Proportional gain, unsigned Q8.8 |
| ki_gain | input | 16 | Integral gain, unsigned Q8.8 |
| phase_err | output | 24 | Signed rounded phase error |
| freq_word | output | 25 | Signed frequency-correction word |
| freq_valid | output | 1 | One-cycle pulse marking a new `freq_word` |

## Verification
Two kinds of fault are expected to appear at the ports within two clocks of a strobe. A wrong product sign or a rounding slip shows up in `phase_err` on the very edge that accepts the sample. A fault in the state machine shows up as a missing or doubled `freq_valid` pulse one edge later. Integrator faults, such as wrapping instead of clamping or a truncation that rounds toward zero, hide inside the held state. They become visible only on the next update's `freq_word`, so the sequences run the integral path alone with kp set to zero and compare every update. The sweep covers sign extremes, rounding boundaries and saturation from both sides. The lock pattern checks that amplitude steps leave the output unchanged.

// File: rtl/qpd_pkg.sv
package qpd_pkg;
    typedef enum logic [0:0] {
        ST_WAIT  = 1'b0,
        ST_ACCUM = 1'b1
    } qpd_state_t;
endpackage

// File: rtl/qpd_cross_detect.sv
module qpd_cross_detect #(
    parameter int IN_W  = 16,
    parameter int ERR_W = 24
) (
    input  logic signed [IN_W-1:0]  grid_i,
    input  logic signed [IN_W-1:0]  grid_q,
    input  logic signed [IN_W-1:0]  est_c,
    input  logic signed [IN_W-1:0]  est_s,
    output logic signed [ERR_W-1:0] err
);
    localparam int PROD_W = 2 * IN_W;
    localparam int SUM_W  = PROD_W + 1;
    localparam int DROP   = SUM_W - ERR_W;

    logic signed [PROD_W-1:0] prod_a;
    logic signed [PROD_W-1:0] prod_b;
    logic signed [SUM_W-1:0]  sum_full;
    logic        [SUM_W-1:0]  sum_rnd;

    always_comb begin
        prod_a   = grid_i * est_c;
        prod_b   = grid_q * est_s;
        sum_full = {prod_a[PROD_W-1], prod_a} + {prod_b[PROD_W-1], prod_b};
        // half-up rounding: add half an output LSB, then keep the top bits
        sum_rnd  = sum_full + (SUM_W'(1) << (DROP - 1));
        err      = sum_rnd[SUM_W-1:DROP];
    end
endmodule

// File: rtl/qpd_seq_fsm.sv
module qpd_seq_fsm
    import qpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe,
    output logic       load_err,
    output logic       do_update,
    output qpd_state_t state_o
);
    qpd_state_t state_q;
    qpd_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_WAIT;
        else     state_q <= state_d;
    end

    always_comb begin
        load_err  = 1'b0;
        do_update = 1'b0;
        state_d   = state_q;
        unique case (state_q)
            ST_WAIT: begin
                load_err = strobe;
                if (strobe) state_d = ST_ACCUM;   // T_ACCEPT
            end
            ST_ACCUM: begin
                do_update = 1'b1;
                state_d   = ST_WAIT;              // T_DONE
            end
            default: state_d = ST_WAIT;
        endcase
    end

    assign state_o = state_q;

    // R8
    accum_leaves_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACCUM) |=> (state_q == ST_WAIT));
endmodule

// File: rtl/qpd_pi_core.sv
module qpd_pi_core #(
    parameter int ERR_W  = 24,
    parameter int GAIN_W = 16,
    parameter int FRAC   = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    update,
    input  logic signed [ERR_W-1:0] err,
    input  logic [GAIN_W-1:0]       kp,
    input  logic [GAIN_W-1:0]       ki,
    output logic signed [ERR_W:0]   out_word,
    output logic                    out_valid
);
    localparam int OUT_W  = ERR_W + 1;
    localparam int MUL_W  = ERR_W + GAIN_W + 1;
    localparam int TERM_W = MUL_W - FRAC;
    localparam int WIDE_W = TERM_W + 2;
    localparam longint LIM = longint'(1) << (ERR_W - 1);
    localparam logic signed [WIDE_W-1:0] HI = WIDE_W'(LIM);
    localparam logic signed [WIDE_W-1:0] LO = -HI;
    localparam logic signed [OUT_W-1:0]  HI_O = OUT_W'(LIM);
    localparam logic signed [OUT_W-1:0]  LO_O = -HI_O;

    function automatic logic signed [OUT_W-1:0] clamp(input logic signed [WIDE_W-1:0] v);
        if (v > HI)      clamp = HI[OUT_W-1:0];
        else if (v < LO) clamp = LO[OUT_W-1:0];
        else             clamp = v[OUT_W-1:0];
    endfunction

    logic signed [GAIN_W:0]    kp_s, ki_s;
    logic signed [MUL_W-1:0]   kp_mul, ki_mul;
    logic signed [TERM_W-1:0]  p_term, i_term;
    logic signed [WIDE_W-1:0]  i_sum, o_sum;
    logic signed [OUT_W-1:0]   integ_q, integ_next;

    always_comb begin
        kp_s       = {1'b0, kp};
        ki_s       = {1'b0, ki};
        kp_mul     = err * kp_s;
        ki_mul     = err * ki_s;
        p_term     = kp_mul[MUL_W-1:FRAC];
        i_term     = ki_mul[MUL_W-1:FRAC];
        i_sum      = WIDE_W'(integ_q) + WIDE_W'(i_term);
        integ_next = clamp(i_sum);
        o_sum      = WIDE_W'(p_term) + WIDE_W'(integ_next);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            integ_q   <= '0;
            out_word  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= update;
            if (update) begin
                integ_q  <= integ_next;
                out_word <= clamp(o_sum);
            end
        end
    end

    // R5
    integ_range_chk: assert property (@(posedge clk) disable iff (rst)
        (integ_q <= HI_O) && (integ_q >= LO_O));
    // R6
    out_range_chk: assert property (@(posedge clk) disable iff (rst)
        (out_word <= HI_O) && (out_word >= LO_O));
    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_word));
endmodule

// File: rtl/qpd_phase_pi.sv
module qpd_phase_pi
    import qpd_pkg::*;
#(
    parameter int IN_W   = 16,
    parameter int ERR_W  = 24,
    parameter int GAIN_W = 16,
    parameter int FRAC   = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sample_valid,
    input  logic signed [IN_W-1:0]  grid_in,
    input  logic signed [IN_W-1:0]  grid_quad,
    input  logic signed [IN_W-1:0]  est_cos,
    input  logic signed [IN_W-1:0]  est_sin,
    input  logic [GAIN_W-1:0]       kp_gain,
    input  logic [GAIN_W-1:0]       ki_gain,
    output logic signed [ERR_W-1:0] phase_err,
    output logic signed [ERR_W:0]   freq_word,
    output logic                    freq_valid
);
    logic signed [ERR_W-1:0] err_comb;
    logic signed [ERR_W-1:0] err_q;
    logic                    load_err;
    logic                    do_update;
    qpd_state_t              state;

    qpd_cross_detect #(.IN_W(IN_W), .ERR_W(ERR_W)) u_detect (
        .grid_i (grid_in),
        .grid_q (grid_quad),
        .est_c  (est_cos),
        .est_s  (est_sin),
        .err    (err_comb)
    );

    qpd_seq_fsm u_seq (
        .clk       (clk),
        .rst       (rst),
        .strobe    (sample_valid),
        .load_err  (load_err),
        .do_update (do_update),
        .state_o   (state)
    );

    always_ff @(posedge clk) begin
        if (rst)           err_q <= '0;
        else if (load_err) err_q <= err_comb;
    end

    qpd_pi_core #(.ERR_W(ERR_W), .GAIN_W(GAIN_W), .FRAC(FRAC)) u_pi (
        .clk       (clk),
        .rst       (rst),
        .update    (do_update),
        .err       (err_q),
        .kp        (kp_gain),
        .ki        (ki_gain),
        .out_word  (freq_word),
        .out_valid (freq_valid)
    );

    assign phase_err = err_q;

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACCUM) |=> $stable(phase_err));
    // R7
    valid_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(freq_valid) |-> ($past(state) == ST_ACCUM));
endmodule

// File: tb/qpd_phase_pi_test.sv
module qpd_phase_pi_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_valid = 1'b0;
    logic signed [15:0] grid_in = '0, grid_quad = '0, est_cos = '0, est_sin = '0;
    logic [15:0] kp_gain = '0, ki_gain = '0;
    logic signed [23:0] phase_err;
    logic signed [24:0] freq_word;
    logic freq_valid;

    int checks = 0;
    int fails  = 0;
    longint m_integ = 0;
    longint m_out   = 0;
    localparam longint LIM = 64'sd8388608;

    always #5 clk = ~clk;

    qpd_phase_pi uut (
        .clk(clk), .rst(rst), .sample_valid(sample_valid),
        .grid_in(grid_in), .grid_quad(grid_quad), .est_cos(est_cos), .est_sin(est_sin),
        .kp_gain(kp_gain), .ki_gain(ki_gain),
        .phase_err(phase_err), .freq_word(freq_word), .freq_valid(freq_valid)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint clampv(input longint v);
        if (v > LIM)  return LIM;
        if (v < -LIM) return -LIM;
        return v;
    endfunction

    function automatic longint exp_err(input longint a, input longint q, input longint c, input longint s);
        longint sum = a * c + q * s;
        return (sum + 256) >>> 9;
    endfunction

    task automatic model_update(input longint e);
        longint p = (longint'(kp_gain) * e) >>> 8;
        m_integ = clampv(m_integ + ((longint'(ki_gain) * e) >>> 8));
        m_out   = clampv(p + m_integ);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        sample_valid = 1'b0;
        repeat (2) @(negedge clk);
        // R1: state while reset is held
        chk("R1 freq_word in reset", longint'(freq_word), 0);
        chk("R1 freq_valid in reset", longint'(freq_valid), 0);
        chk("R1 phase_err in reset", longint'(phase_err), 0);
        rst = 1'b0;
        m_integ = 0;
        m_out = 0;
    endtask

    task automatic sample(input longint a, input longint q, input longint c, input longint s, input string tag);
        longint e;
        @(negedge clk);
        grid_in = 16'(a); grid_quad = 16'(q); est_cos = 16'(c); est_sin = 16'(s);
        sample_valid = 1'b1;
        e = exp_err(a, q, c, s);
        @(negedge clk);
        sample_valid = 1'b0;
        chk("R2 phase_err", longint'(phase_err), e);
        chk("R7 no early valid", longint'(freq_valid), 0);
        @(negedge clk);
        model_update(e);
        chk("R7 valid pulse", longint'(freq_valid), 1);
        chk(tag, longint'(freq_word), m_out);
        @(negedge clk);
        chk("R7 valid drops", longint'(freq_valid), 0);
        chk("R9 freq_word held", longint'(freq_word), m_out);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        longint vals[7] = '{-32768, -300, -1, 0, 1, 256, 32767};
        do_reset();
        @(negedge clk);
        // R1: first edges after reset release
        chk("R1 freq_word after reset", longint'(freq_word), 0);
        chk("R1 freq_valid after reset", longint'(freq_valid), 0);

        // R2/R3: sweep with unity proportional gain, no integral
        kp_gain = 16'd256; ki_gain = 16'd0;
        foreach (vals[i]) foreach (vals[j]) foreach (vals[k]) foreach (vals[l])
            sample(vals[i], vals[j], vals[k], vals[l], "R3 freq_word unity kp");

        // R2: rounding boundaries at exactly half an LSB
        sample(256, 0, 1, 0, "R3 round +half");
        sample(-256, 0, 1, 0, "R3 round -half");
        sample(-257, 0, 1, 0, "R3 round below -half");

        // R4: integral-only accumulation with fractional gain and floor
        do_reset();
        kp_gain = 16'd0; ki_gain = 16'd3;
        for (int n = 0; n < 12; n++)
            sample(1000 * (n - 6), -700, 20000, 15000 - 2500 * n, "R4 integrator step");
        ki_gain = 16'd256; kp_gain = 16'd128;
        for (int n = 0; n < 8; n++)
            sample(-4000 * n, 9000, 30000, -3000, "R3 proportional plus integral");

        // R5: integrator saturation both ways, seen with kp zero
        do_reset();
        kp_gain = 16'd0; ki_gain = 16'hFFFF;
        sample(32767, 0, 32767, 0, "R5 integrator positive clamp");
        chk("R5 clamp value +", longint'(freq_word), LIM);
        sample(32767, 0, 32767, 0, "R5 integrator stays clamped");
        sample(-32768, 0, 32767, 0, "R5 integrator negative clamp");
        chk("R5 clamp value -", longint'(freq_word), -LIM);
        ki_gain = 16'd256;
        sample(0, 0, 0, 0, "R5 zero error keeps clamp");

        // R6: output saturation from the proportional path
        do_reset();
        kp_gain = 16'hFFFF; ki_gain = 16'd0;
        sample(32767, 0, 32767, 0, "R6 output positive clamp");
        chk("R6 clamp value +", longint'(freq_word), LIM);
        sample(0, 32767, 0, -32768, "R6 output negative clamp");
        chk("R6 clamp value -", longint'(freq_word), -LIM);

        // R8: back-to-back strobe is ignored
        do_reset();
        kp_gain = 16'd256; ki_gain = 16'd64;
        @(negedge clk);
        grid_in = 16'sd12000; grid_quad = 16'sd0; est_cos = 16'sd20000; est_sin = 16'sd0;
        sample_valid = 1'b1;
        @(negedge clk);
        grid_in = -16'sd30000; est_cos = 16'sd30000;
        @(negedge clk);
        sample_valid = 1'b0;
        model_update(exp_err(12000, 0, 20000, 0));
        chk("R8 phase_err keeps first", longint'(phase_err), exp_err(12000, 0, 20000, 0));
        chk("R8 single valid", longint'(freq_valid), 1);
        chk("R8 output from first", longint'(freq_word), m_out);
        @(negedge clk);
        chk("R8 no second valid", longint'(freq_valid), 0);
        chk("R8 output unchanged", longint'(freq_word), m_out);
        repeat (3) @(negedge clk);
        chk("R8 still no valid", longint'(freq_valid), 0);

        // R10: locked inputs at several amplitudes leave output unchanged
        sample(5000, 0, 30000, 0, "R10 preload");
        for (int a = 1; a <= 8000; a = a * 3) begin
            sample(3 * a, 4 * a, -24000, 18000, "R10 locked output holds");
            chk("R10 zero error", longint'(phase_err), 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule